// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers 96 peripheral interrupt request lines into 12 groups of 8 and drives one CPU-level interrupt line per group. Each source has a latched pending flag and an enable bit inside its group. Each group has an acknowledge latch that holds the group back from the CPU after one of its interrupts is taken, until software releases it. A group request that passes the enables travels through a fixed five-cycle delivery pipeline into a CPU-level flag. The CPU-level flag is gated by a CPU-level enable and a global mask to form the interrupt lines.

The CPU takes an interrupt by pulsing `intAccept` with a group number. On the next cycle the block returns the vector of the highest-priority enabled pending source in that group. The vector comes from a table that software can only write while an unlock bit is set. In the same step the block clears that source's flag and the group's CPU-level flag, and it sets the group's acknowledge latch. Software configures the block through a single-cycle register port with a combinational read.

Top module: `gpie_expander`

## Requirements
- R1: After reset every source flag, group enable, acknowledge bit, CPU flag, CPU enable, vector entry and response output is zero. The control register at address 0x23 reads 1: bit 0 is the global mask and resets to 1, bit 1 is the unlock bit and resets to 0.
- R2: A source flag (group g at address 0x10+g, bit s for request input g*8+s) sets on a rising edge of its request input, and only then. A request held high does not set the flag again once it has been cleared. Writing 1 to a flag bit clears it.
- R3: A group is requesting when any flag in it that is also enabled (address 0x00+g) is set and its acknowledge bit is clear. When a group starts requesting, its CPU flag (address 0x21, bit g) sets exactly 5 clock edges after the edge that made the request visible. Clearing the enable after the request has started does not cancel that delivery.
- R4: While a group's acknowledge bit (address 0x20, bit g) is set, the group delivers nothing new. Writing 1 to the bit releases it, and a flag that is still pending is then delivered.
- R5: When `intAccept` is high with a group below 12 and the group has an enabled pending source, the next cycle shows `vecValid`=1, `vecSrc` set to the source index and `vecData` set to the table entry at index g*8+s. The same edge clears that source flag and CPU flag g and sets acknowledge bit g.
- R6: Within a group, the lowest-numbered enabled pending source is served first. `intTopGroup` names the lowest-numbered group whose interrupt line is active.
- R7: When a flag's rising request coincides with a clear by service or by software write in the same cycle, the flag stays set.
- R8: A write to a vector entry (address 0x80+index, index below 96) takes effect only while the unlock bit is 1. Otherwise the entry keeps its value.
- R9: While the global mask bit is 1, all `cpuIntReq` lines are 0. CPU flags still set and can be read at address 0x21.
- R10: Writing 1 to a CPU flag bit clears it. Clearing a group enable leaves that group's flags unchanged. `cpuIntReq` bit g is CPU flag g AND CPU enable g (address 0x22) AND NOT the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphReq | input | 96 | Peripheral request lines, bit g*8+s for group g source s |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr (combinational) |
| intAccept | input | 1 | CPU accepts an interrupt this cycle |
| intGroup | input | 4 | Group being accepted |
| cpuIntReq | output | 12 | CPU-level interrupt lines, one per group |
| intAny | output | 1 | Any CPU-level line active |
| intTopGroup | output | 4 | Lowest-numbered active group |
| vecValid | output | 1 | Vector response valid (one cycle after accept) |
| vecData | output | 16 | Vector of the served source |
| vecSrc | output | 3 | Index of the served source within its group |

## Verification
The accept path is tried in several cases:
- With two sources pending in one group, which tells lowest-index priority apart from arrival order.
- With two groups pending, so the top-group output is tested against the group number.
- Again after an acknowledge release, which separates gated requests from lost ones.

Request edges are placed in the same cycle as a service clear and as a software clear, so a set-wins flag can be told from a clear-wins one. A level held high after a clear separates edge detection from level sensing. A single request is timed edge by edge to pin the delivery latency at exactly five. An enable removed mid-flight shows that the pipeline carries the request regardless. Vector writes are issued both locked and unlocked to separate the two protection states.

// File: rtl/gpie_pkg.sv
package gpie_pkg;
  parameter int NUM_GROUPS    = 12;
  parameter int SRC_PER_GROUP = 8;
  parameter int DELIVER_LAT   = 5;
  parameter int DATA_W        = 16;
  parameter int VEC_W         = 16;
  parameter int ADDR_W        = 8;

  localparam int NUM_SRC = NUM_GROUPS * SRC_PER_GROUP;
  localparam int GRP_W   = $clog2(NUM_GROUPS);
  localparam int SRC_W   = $clog2(SRC_PER_GROUP);
  localparam int VIDX_W  = $clog2(NUM_SRC);
  localparam int STAGES  = DELIVER_LAT - 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_EN, SEL_FLAG, SEL_ACK, SEL_CPUFLAG, SEL_CPUEN, SEL_CTRL, SEL_VEC
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e            sel;
    logic [GRP_W-1:0]    selGrp;
    logic [VIDX_W-1:0]   selVec;
    logic [DATA_W-1:0]   wdata;
    logic                enWr;
    logic                flagClr;
    logic                ackClr;
    logic                cpuFlagClr;
    logic                cpuEnWr;
    logic                ctrlWr;
    logic                vecWr;
    logic                accept;
    logic [GRP_W-1:0]    accGroup;
  } strobe_t;
endpackage

// File: rtl/gpie_ctrl.sv
module gpie_ctrl
  import gpie_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              intAccept,
  input  logic [GRP_W-1:0]  intGroup,
  output strobe_t           stb
);
  logic [3:0] page;
  logic [3:0] low;

  assign page = regAddr[7:4];
  assign low  = regAddr[3:0];

  always_comb begin
    stb          = '0;
    stb.sel      = SEL_NONE;
    stb.wdata    = regWdata;
    stb.selGrp   = GRP_W'(low);
    stb.selVec   = VIDX_W'(regAddr[6:0]);
    stb.accept   = intAccept && (int'(intGroup) < NUM_GROUPS);
    stb.accGroup = intGroup;
    if (regAddr[7]) begin
      if (regAddr[6:0] < 7'(NUM_SRC)) stb.sel = SEL_VEC;
    end else begin
      case (page)
        4'h0: if (low < 4'(NUM_GROUPS)) stb.sel = SEL_EN;
        4'h1: if (low < 4'(NUM_GROUPS)) stb.sel = SEL_FLAG;
        4'h2: begin
          case (low)
            4'h0:    stb.sel = SEL_ACK;
            4'h1:    stb.sel = SEL_CPUFLAG;
            4'h2:    stb.sel = SEL_CPUEN;
            4'h3:    stb.sel = SEL_CTRL;
            default: stb.sel = SEL_NONE;
          endcase
        end
        default: stb.sel = SEL_NONE;
      endcase
    end
    stb.enWr       = regWe && (stb.sel == SEL_EN);
    stb.flagClr    = regWe && (stb.sel == SEL_FLAG);
    stb.ackClr     = regWe && (stb.sel == SEL_ACK);
    stb.cpuFlagClr = regWe && (stb.sel == SEL_CPUFLAG);
    stb.cpuEnWr    = regWe && (stb.sel == SEL_CPUEN);
    stb.ctrlWr     = regWe && (stb.sel == SEL_CTRL);
    stb.vecWr      = regWe && (stb.sel == SEL_VEC);
  end
endmodule

// File: rtl/gpie_datapath.sv
module gpie_datapath
  import gpie_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [NUM_SRC-1:0]    reqIn,
  output logic [NUM_GROUPS-1:0] cpuIntReq,
  output logic                  intAny,
  output logic [GRP_W-1:0]      intTopGroup,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecData,
  output logic [SRC_W-1:0]      vecSrc,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_GROUPS-1:0] ackBits,
  output logic [NUM_GROUPS-1:0] cpuFlagBits,
  output logic                  globalMask
);
  logic [NUM_GROUPS-1:0][SRC_PER_GROUP-1:0] flag, en, flagSet, flagClrM;
  logic [NUM_GROUPS-1:0] ack, cpuFlag, cpuEn, grpReq, grpReqPrev, pulse, deliver;
  logic [NUM_GROUPS-1:0] grpOneHot, ackSetM, ackClrM, cpuClrM;
  logic                  mask, unlock, svcHit;
  logic [NUM_SRC-1:0]    reqPrev;
  logic [VEC_W-1:0]      vecRam [NUM_SRC];
  logic [SRC_PER_GROUP-1:0] accLive;
  logic [SRC_W-1:0]      pickSrc;
  logic [VIDX_W-1:0]     pickIdx;

  // Group request: any enabled pending source, held back by the acknowledge latch
  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) grpReq[g] = (|(flag[g] & en[g])) & ~ack[g];
  end
  assign pulse = grpReq & ~grpReqPrev;

  // Delivery pipeline: depth picked by the latency parameter
  generate
    if (STAGES == 0) begin : g_direct
      assign deliver = pulse;
    end else begin : g_pipe
      logic [STAGES-1:0][NUM_GROUPS-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else begin
          stage[0] <= pulse;
          for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
      end
      assign deliver = stage[STAGES-1];
    end
  endgenerate

  // Priority pick inside the accepted group: lowest index wins
  always_comb begin
    accLive = stb.accept ? (flag[stb.accGroup] & en[stb.accGroup]) : '0;
    pickSrc = '0;
    for (int s = SRC_PER_GROUP - 1; s >= 0; s--) if (accLive[s]) pickSrc = SRC_W'(s);
    svcHit  = |accLive;
    pickIdx = VIDX_W'(int'(stb.accGroup) * SRC_PER_GROUP + int'(pickSrc));
  end

  always_comb begin
    flagSet   = reqIn & ~reqPrev;
    grpOneHot = stb.accept ? (NUM_GROUPS'(1) << stb.accGroup) : '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      flagClrM[g] = ((stb.flagClr && stb.selGrp == GRP_W'(g)) ? stb.wdata[SRC_PER_GROUP-1:0] : '0)
                  | ((svcHit && stb.accGroup == GRP_W'(g)) ? (SRC_PER_GROUP'(1) << pickSrc) : '0);
    end
    ackSetM = svcHit ? grpOneHot : '0;
    ackClrM = stb.ackClr ? stb.wdata[NUM_GROUPS-1:0] : '0;
    cpuClrM = (stb.cpuFlagClr ? stb.wdata[NUM_GROUPS-1:0] : '0) | grpOneHot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= '0; en <= '0; ack <= '0; cpuFlag <= '0; cpuEn <= '0;
      mask <= 1'b1; unlock <= 1'b0; reqPrev <= '0; grpReqPrev <= '0;
      vecValid <= 1'b0; vecData <= '0; vecSrc <= '0;
    end else begin
      reqPrev    <= reqIn;
      grpReqPrev <= grpReq;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        flag[g] <= (flag[g] & ~flagClrM[g]) | flagSet[g];   // set wins
        if (stb.enWr && stb.selGrp == GRP_W'(g)) en[g] <= stb.wdata[SRC_PER_GROUP-1:0];
      end
      ack     <= (ack & ~ackClrM) | ackSetM;
      cpuFlag <= (cpuFlag & ~cpuClrM) | deliver;
      if (stb.cpuEnWr) cpuEn <= stb.wdata[NUM_GROUPS-1:0];
      if (stb.ctrlWr) {unlock, mask} <= stb.wdata[1:0];
      vecValid <= svcHit;
      if (svcHit) begin
        vecData <= vecRam[pickIdx];
        vecSrc  <= pickSrc;
      end
    end
  end

  // Write-protected vector table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) vecRam[i] <= '0;
    end else if (stb.vecWr && unlock) begin
      vecRam[stb.selVec] <= stb.wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    cpuIntReq   = cpuFlag & cpuEn & {NUM_GROUPS{~mask}};
    intAny      = |cpuIntReq;
    intTopGroup = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) if (cpuIntReq[g]) intTopGroup = GRP_W'(g);
  end

  always_comb begin
    case (stb.sel)
      SEL_EN:      rdData = DATA_W'(en[stb.selGrp]);
      SEL_FLAG:    rdData = DATA_W'(flag[stb.selGrp]);
      SEL_ACK:     rdData = DATA_W'(ack);
      SEL_CPUFLAG: rdData = DATA_W'(cpuFlag);
      SEL_CPUEN:   rdData = DATA_W'(cpuEn);
      SEL_CTRL:    rdData = DATA_W'({unlock, mask});
      SEL_VEC:     rdData = DATA_W'(vecRam[stb.selVec]);
      default:     rdData = '0;
    endcase
  end

  assign ackBits     = ack;
  assign cpuFlagBits = cpuFlag;
  assign globalMask  = mask;
endmodule

// File: rtl/gpie_expander.sv
module gpie_expander
  import gpie_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    periphReq,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic                  intAccept,
  input  logic [GRP_W-1:0]      intGroup,
  output logic [NUM_GROUPS-1:0] cpuIntReq,
  output logic                  intAny,
  output logic [GRP_W-1:0]      intTopGroup,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecData,
  output logic [SRC_W-1:0]      vecSrc
);
  strobe_t               stb;
  logic [NUM_GROUPS-1:0] ackBits;
  logic [NUM_GROUPS-1:0] cpuFlagBits;
  logic                  globalMask;

  gpie_ctrl i_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .intAccept(intAccept), .intGroup(intGroup), .stb(stb)
  );

  gpie_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqIn(periphReq),
    .cpuIntReq(cpuIntReq), .intAny(intAny), .intTopGroup(intTopGroup),
    .vecValid(vecValid), .vecData(vecData), .vecSrc(vecSrc), .rdData(regRdata),
    .ackBits(ackBits), .cpuFlagBits(cpuFlagBits), .globalMask(globalMask)
  );
endmodule

// File: rtl/gpie_checker.sv
module gpie_checker
  import gpie_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  intAccept,
  input logic [GRP_W-1:0]      intGroup,
  input logic                  vecValid,
  input logic [NUM_GROUPS-1:0] cpuIntReq,
  input logic                  intAny,
  input logic [GRP_W-1:0]      intTopGroup,
  input logic [NUM_GROUPS-1:0] ackBits,
  input logic [NUM_GROUPS-1:0] cpuFlagBits,
  input logic                  globalMask
);
  p_vec_follows_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAccept));

  p_ack_after_service_r4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ackBits[$past(intGroup)]);

  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    globalMask |-> (cpuIntReq == '0));

  p_line_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIntReq & ~cpuFlagBits) == '0);

  p_top_is_lowest_r6: assert property (@(posedge clk) disable iff (!rstN)
    intAny |-> (cpuIntReq[intTopGroup] &&
                ((cpuIntReq & ((NUM_GROUPS'(1) << intTopGroup) - NUM_GROUPS'(1))) == '0)));
endmodule

bind gpie_expander gpie_checker i_gpie_checker (
  .clk(clk), .rstN(rstN), .intAccept(intAccept), .intGroup(intGroup),
  .vecValid(vecValid), .cpuIntReq(cpuIntReq), .intAny(intAny), .intTopGroup(intTopGroup),
  .ackBits(ackBits), .cpuFlagBits(cpuFlagBits), .globalMask(globalMask)
);

// File: tb/test_gpie_expander.sv
module test_gpie_expander;
  import gpie_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [95:0] periphReq = '0;
  logic        regWe = 0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        intAccept = 0;
  logic [3:0]  intGroup = '0;
  logic [11:0] cpuIntReq;
  logic        intAny;
  logic [3:0]  intTopGroup;
  logic        vecValid;
  logic [15:0] vecData;
  logic [2:0]  vecSrc;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  gpie_expander i_gpie_expander (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .intAccept(intAccept), .intGroup(intGroup),
    .cpuIntReq(cpuIntReq), .intAny(intAny), .intTopGroup(intTopGroup),
    .vecValid(vecValid), .vecData(vecData), .vecSrc(vecSrc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0]  mFlag [12];
  bit [7:0]  mEn [12];
  bit [11:0] mAck, mCpuFlag, mCpuEn, mGrpPrev;
  bit        mMask, mUnlock;
  bit [15:0] mVec [96];
  bit [95:0] mReqPrev;
  int        dueQ [12][$];
  int        edgeN;
  bit        mVecValid;
  bit [15:0] mVecData;
  bit [2:0]  mVecSrc;

  function automatic void decodeAddr(input logic [7:0] addr, output int kind, output int idx);
    int a = int'(addr);
    kind = 0; idx = 0;
    if (a >= 128 && a < 128 + 96) begin kind = 7; idx = a - 128; end
    else if (a < 12) begin kind = 1; idx = a; end
    else if (a >= 16 && a < 28) begin kind = 2; idx = a - 16; end
    else if (a == 32) kind = 3;
    else if (a == 33) kind = 4;
    else if (a == 34) kind = 5;
    else if (a == 35) kind = 6;
  endfunction

  function automatic logic [15:0] expRd(input logic [7:0] addr);
    int kind, idx;
    decodeAddr(addr, kind, idx);
    case (kind)
      1: return {8'h0, mEn[idx]};
      2: return {8'h0, mFlag[idx]};
      3: return {4'h0, mAck};
      4: return {4'h0, mCpuFlag};
      5: return {4'h0, mCpuEn};
      6: return {14'h0, mUnlock, mMask};
      7: return mVec[idx];
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelStep();
    bit [11:0] now, dlv, oneHot, swAck, swCpu;
    bit        hit;
    int        src, kind, idx;
    bit [7:0]  setm, clr;
    now = '0; dlv = '0; oneHot = '0; hit = 0; src = 0;
    for (int g = 0; g < 12; g++) now[g] = (|(mFlag[g] & mEn[g])) && !mAck[g];
    for (int g = 0; g < 12; g++)
      if (dueQ[g].size() > 0 && dueQ[g][0] == edgeN) begin
        dlv[g] = 1;
        void'(dueQ[g].pop_front());
      end
    for (int g = 0; g < 12; g++)
      if (now[g] && !mGrpPrev[g]) dueQ[g].push_back(edgeN + DELIVER_LAT - 1);
    if (intAccept && intGroup < 12) begin
      oneHot[intGroup] = 1;
      for (int s = 7; s >= 0; s--)
        if (mFlag[intGroup][s] && mEn[intGroup][s]) begin hit = 1; src = s; end
    end
    mVecValid = hit;
    if (hit) begin
      mVecData = mVec[intGroup * 8 + src];
      mVecSrc  = 3'(src);
    end
    decodeAddr(regAddr, kind, idx);
    for (int g = 0; g < 12; g++) begin
      setm = periphReq[g*8 +: 8] & ~mReqPrev[g*8 +: 8];
      clr  = '0;
      if (regWe && kind == 2 && idx == g) clr = regWdata[7:0];
      if (hit && g == int'(intGroup)) clr[src] = 1;
      mFlag[g] = (mFlag[g] & ~clr) | setm;
      if (regWe && kind == 1 && idx == g) mEn[g] = regWdata[7:0];
    end
    swAck = (regWe && kind == 3) ? regWdata[11:0] : '0;
    swCpu = (regWe && kind == 4) ? regWdata[11:0] : '0;
    mAck     = (mAck & ~swAck) | (hit ? oneHot : 12'h0);
    mCpuFlag = (mCpuFlag & ~swCpu & ~oneHot) | dlv;
    if (regWe && kind == 7 && mUnlock) mVec[idx] = regWdata;
    if (regWe && kind == 5) mCpuEn = regWdata[11:0];
    if (regWe && kind == 6) begin mMask = regWdata[0]; mUnlock = regWdata[1]; end
    mReqPrev = periphReq;
    mGrpPrev = now;
    edgeN++;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < 12; g++) begin mFlag[g] = 0; mEn[g] = 0; dueQ[g].delete(); end
      for (int i = 0; i < 96; i++) mVec[i] = 0;
      mAck = 0; mCpuFlag = 0; mCpuEn = 0; mGrpPrev = 0; mReqPrev = 0;
      mMask = 1; mUnlock = 0; mVecValid = 0; mVecData = 0; mVecSrc = 0; edgeN = 0;
    end else begin
      modelStep();
    end
  end

  // Lockstep comparison on every cycle
  always begin
    logic [11:0] expReq;
    int          expTop;
    @(negedge clk);
    #1;
    if (rstN) begin
      expReq = mCpuFlag & mCpuEn & {12{!mMask}};
      expTop = 0;
      for (int g = 11; g >= 0; g--) if (expReq[g]) expTop = g;
      chk("R3 lockstep cpuIntReq", {20'h0, cpuIntReq}, {20'h0, expReq});
      chk("R6 lockstep intTopGroup", {28'h0, intTopGroup}, expTop);
      chk("R5 lockstep vecValid", {31'h0, vecValid}, {31'h0, mVecValid});
      if (mVecValid) begin
        chk("R5 lockstep vecData", {16'h0, vecData}, {16'h0, mVecData});
        chk("R5 lockstep vecSrc", {29'h0, vecSrc}, {29'h0, mVecSrc});
      end
      chk("R10 lockstep regRdata", {16'h0, regRdata}, {16'h0, expRd(regAddr)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    regWe = 0; regAddr = a;
    #2;
    v = regRdata;
  endtask

  task automatic acceptGroup(input logic [3:0] g);
    @(negedge clk);
    intAccept = 1; intGroup = g;
    @(negedge clk);
    intAccept = 0;
    #2;
  endtask

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1: reset state
    rd(8'h23, v); chk("R1 ctrl after reset", {16'h0, v}, 32'h1);
    rd(8'h80, v); chk("R1 vector entry after reset", {16'h0, v}, 32'h0);
    chk("R1 cpuIntReq after reset", {20'h0, cpuIntReq}, 32'h0);

    // R8: protected vector table
    wr(8'h22, 16'h0FFF);
    wr(8'h8A, 16'hBEEF);
    rd(8'h8A, v); chk("R8 locked write ignored", {16'h0, v}, 32'h0);
    wr(8'h23, 16'h0002);
    wr(8'h8A, 16'hBEEF);
    wr(8'h8D, 16'h1155);
    rd(8'h8A, v); chk("R8 unlocked write lands", {16'h0, v}, 32'hBEEF);

    // R3: five-edge delivery latency
    wr(8'h01, 16'h00FF);
    @(negedge clk); periphReq[10] = 1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk); #2;
      if (k == 5) chk("R3 not yet delivered at edge 4", {31'h0, cpuIntReq[1]}, 32'h0);
      if (k == 6) chk("R3 delivered at edge 5", {31'h0, cpuIntReq[1]}, 32'h1);
    end

    // R6: priority within a group and across groups
    wr(8'h03, 16'h00FF);
    @(negedge clk); periphReq[13] = 1; periphReq[24] = 1;
    tick(8);
    #2;
    chk("R6 top group is lowest", {28'h0, intTopGroup}, 32'h1);
    acceptGroup(4'd1);
    chk("R5 vecValid after accept", {31'h0, vecValid}, 32'h1);
    chk("R6 lowest source served first", {29'h0, vecSrc}, 32'h2);
    chk("R5 vector from table", {16'h0, vecData}, 32'hBEEF);
    rd(8'h11, v); chk("R5 served flag cleared, other kept", {16'h0, v}, 32'h20);
    rd(8'h20, v); chk("R4 ack set by service", {16'h0, v}, 32'h2);

    // R4: acknowledge gating and release
    tick(8); #2;
    chk("R4 gated group silent", {31'h0, cpuIntReq[1]}, 32'h0);
    chk("R6 next group on top", {28'h0, intTopGroup}, 32'h3);
    wr(8'h20, 16'h0002);
    tick(7); #2;
    chk("R4 pending source delivered after release", {31'h0, cpuIntReq[1]}, 32'h1);

    // R7: set wins over service clear
    @(negedge clk); periphReq[13] = 0;
    @(negedge clk); intAccept = 1; intGroup = 4'd1; periphReq[13] = 1;
    @(negedge clk); intAccept = 0; #2;
    chk("R5 second service source", {29'h0, vecSrc}, 32'h5);
    chk("R5 second service vector", {16'h0, vecData}, 32'h1155);
    rd(8'h11, v); chk("R7 set wins over service clear", {16'h0, v}, 32'h20);

    // R7: set wins over software clear; R2: held level does not re-set
    @(negedge clk); periphReq[13] = 0;
    @(negedge clk); regWe = 1; regAddr = 8'h11; regWdata = 16'h0020; periphReq[13] = 1;
    @(negedge clk); regWe = 0;
    rd(8'h11, v); chk("R7 set wins over software clear", {16'h0, v}, 32'h20);
    wr(8'h11, 16'h0020);
    tick(2);
    rd(8'h11, v); chk("R2 held request does not re-set flag", {16'h0, v}, 32'h0);

    // R9: global mask blocks lines, flags still accumulate; R8 locked again
    wr(8'h23, 16'h0001);
    #2;
    chk("R9 mask blocks all lines", {20'h0, cpuIntReq}, 32'h0);
    rd(8'h21, v); chk("R9 CPU flag still set under mask", {31'h0, v[3]}, 32'h1);
    wr(8'h8A, 16'h1234);
    rd(8'h8A, v); chk("R8 write after relock ignored", {16'h0, v}, 32'hBEEF);

    // R10: enable clear keeps flags; CPU flag software clear
    wr(8'h03, 16'h0000);
    rd(8'h13, v); chk("R10 flags kept after enable clear", {16'h0, v}, 32'h1);
    wr(8'h21, 16'h0008);
    rd(8'h21, v); chk("R10 CPU flag cleared by software", {31'h0, v[3]}, 32'h0);

    // R3: disabling after the request started does not cancel delivery
    wr(8'h05, 16'h00FF);
    @(negedge clk); periphReq[40] = 1;
    tick(2);
    wr(8'h05, 16'h0000);
    tick(5);
    rd(8'h21, v); chk("R3 in-flight request still delivered", {31'h0, v[5]}, 32'h1);

    tick(3);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule